// File: doc/BRIEF.md
# Double-Buffered Configuration Register Bank

This block is a byte-wide configuration register file addressed over an 8-bit space. It sits behind a serial control front end, which presents a simple write port and a read port. Most implemented registers are double-buffered. A write only changes the staged copy. The active copy, which drives device functions, loads every staged value together when software writes the commit bit at address 0xFF.

Four addresses bypass the staging stage, and a write to one of them changes the active copy at once: 0x00, 0x02, 0x04 and 0x05. The chip setup area covers 0x00 to 0x02, plus the two direct index bytes at 0x04 and 0x05. The function area covers 0x08 to 0x2D. Bit 0 of 0x09 enables the clock duty-cycle stabiliser, which is on after reset. All active bytes are exported as one flat vector, and the stabiliser enable also has an output of its own.

Top module: `cfgbank_top`

## Requirements
- R1: After reset, both the staged and the active copy of every register hold the default. 0x09 defaults to 0x01 and every other register to 0x00. Address 0xFF reads 0x00 and `stab_clk_en` is 1.
- R2: A write to a buffered address (0x01, or 0x08 to 0x2D) leaves the readback value, `active_cfg` and `stab_clk_en` unchanged until a commit.
- R3: Writing a byte with bit 0 set to 0xFF sets the commit bit at that clock edge. At the next edge, every buffered active byte loads its staged value.
- R4: A write to 0x00, 0x02, 0x04 or 0x05 takes effect at its own clock edge, in readback and in `active_cfg`, without a commit.
- R5: Address 0xFF reads 0x01 in the cycle after the commit write and 0x00 once the commit is done. A write to 0xFF with bit 0 clear starts no commit.
- R6: Reads of unimplemented addresses (0x03, 0x06, 0x07, 0x2E to 0xFE) return 0x00. Writes to them change no register.
- R7: If a buffered register is written in the same cycle as a pending commit, the commit transfers the value staged before that write. The new value reaches the active copy at the following commit.
- R8: `stab_clk_en` equals bit 0 of the active copy of 0x09. Clearing that bit turns the output off only after a commit.
- R9: `rd_valid` is high exactly one cycle after each cycle with `rd_en` high. `rd_data` then holds the value from before any write in the read cycle. Buffered addresses return their active value.
- R10: `active_cfg` holds 43 byte slots, with slot k at bits [8k+7:8k]. The slots follow this address order: 0x00, 0x01, 0x02, 0x04, 0x05, then 0x08 up to 0x2D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, loads defaults |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Read data, registered |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| active_cfg | output | 344 | All active bytes, slot order per R10 |
| stab_clk_en | output | 1 | Duty-cycle stabiliser enable (0x09 bit 0, active) |

## Verification
The hardest case to reach is a buffered write that lands in the single cycle when a commit is pending. That window exists only on the clock edge right after a write to 0xFF. The stimulus therefore issues the commit write and the register write back to back. It reads the register after the first commit and again after a second commit, which separates the old staged value from the new one. A read issued in the same cycle as a direct write also confirms that the read captures the value from before the write.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;

    // Slots taken by the chip setup area: 0x00, 0x01, 0x02, 0x04, 0x05
    localparam int CHIP_SLOTS = 5;

    // Address held by a given storage slot
    function automatic logic [7:0] slot_to_addr(input int k, input logic [7:0] func_lo);
        if (k < 3)               return 8'(k);
        else if (k < CHIP_SLOTS) return 8'(k + 1);
        else                     return 8'(int'(func_lo) + k - CHIP_SLOTS);
    endfunction

    // Slots that skip the staging stage (0x00, 0x02, 0x04, 0x05)
    function automatic logic slot_is_direct(input int k);
        return (k == 0) || (k == 2) || (k == 3) || (k == 4);
    endfunction

    function automatic logic [7:0] slot_default(input int k, input logic [7:0] func_lo,
                                                input logic [7:0] stab_addr,
                                                input logic [7:0] stab_dflt);
        return (slot_to_addr(k, func_lo) == stab_addr) ? stab_dflt : 8'h00;
    endfunction

endpackage

// File: rtl/cfgbank_decode.sv
module cfgbank_decode
    import cfgbank_pkg::*;
#(
    parameter logic [7:0] FUNC_LO   = 8'h08,
    parameter logic [7:0] FUNC_HI   = 8'h2D,
    parameter logic [7:0] XFER_ADDR = 8'hFF,
    parameter int         SW        = 6
) (
    input  logic [7:0]    addr,
    output logic          hit,
    output logic          direct,
    output logic          is_xfer,
    output logic [SW-1:0] slot
);

    always_comb begin
        hit     = 1'b0;
        direct  = 1'b0;
        slot    = '0;
        is_xfer = (addr == XFER_ADDR);
        if (addr <= 8'h02) begin
            hit    = 1'b1;
            slot   = SW'(addr);
            direct = (addr != 8'h01);
        end else if (addr == 8'h04 || addr == 8'h05) begin
            hit    = 1'b1;
            slot   = SW'(addr - 8'h01);
            direct = 1'b1;
        end else if (addr >= FUNC_LO && addr <= FUNC_HI) begin
            hit    = 1'b1;
            slot   = SW'(int'(addr) - int'(FUNC_LO) + CHIP_SLOTS);
        end
    end

endmodule

// File: rtl/cfgbank_store.sv
module cfgbank_store
    import cfgbank_pkg::*;
#(
    parameter int         NSLOT     = 43,
    parameter int         SW        = 6,
    parameter logic [7:0] FUNC_LO   = 8'h08,
    parameter logic [7:0] STAB_ADDR = 8'h09,
    parameter logic [7:0] STAB_DFLT = 8'h01
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  wr_hit,
    input  logic                  wr_direct,
    input  logic                  wr_xfer,
    input  logic [SW-1:0]         wr_slot,
    input  logic [7:0]            wr_data,
    input  logic                  rd_en,
    input  logic                  rd_hit,
    input  logic                  rd_xfer,
    input  logic [SW-1:0]         rd_slot,
    output logic [7:0]            rd_data,
    output logic                  rd_valid,
    output logic [NSLOT-1:0][7:0] active,
    output logic                  commit
);

    typedef struct packed {
        logic [NSLOT-1:0][7:0] stage;
        logic [NSLOT-1:0][7:0] active;
        logic                  xfer;
        logic [7:0]            rdata;
        logic                  rvalid;
    } bank_t;

    function automatic logic [NSLOT-1:0] build_direct_mask();
        logic [NSLOT-1:0] m;
        for (int k = 0; k < NSLOT; k++) m[k] = slot_is_direct(k);
        return m;
    endfunction

    function automatic bank_t build_reset();
        bank_t r;
        r = '0;
        for (int k = 0; k < NSLOT; k++) begin
            r.stage[k]  = slot_default(k, FUNC_LO, STAB_ADDR, STAB_DFLT);
            r.active[k] = slot_default(k, FUNC_LO, STAB_ADDR, STAB_DFLT);
        end
        return r;
    endfunction

    localparam logic [NSLOT-1:0] DIRECT_MASK = build_direct_mask();
    localparam bank_t            RESET_VAL   = build_reset();

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d        = bank_q;
        bank_d.rvalid = rd_en;
        if (rd_en) begin
            if (rd_hit)       bank_d.rdata = bank_q.active[rd_slot];
            else if (rd_xfer) bank_d.rdata = {7'b0, bank_q.xfer};
            else              bank_d.rdata = 8'h00;
        end
        // pending commit moves staged bytes using pre-write staged state
        if (bank_q.xfer) begin
            for (int k = 0; k < NSLOT; k++) begin
                if (!DIRECT_MASK[k]) bank_d.active[k] = bank_q.stage[k];
            end
            bank_d.xfer = 1'b0;
        end
        if (wr_en) begin
            if (wr_hit) begin
                bank_d.stage[wr_slot] = wr_data;
                if (wr_direct) bank_d.active[wr_slot] = wr_data;
            end else if (wr_xfer) begin
                bank_d.xfer = wr_data[0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= RESET_VAL;
        else        bank_q <= bank_d;
    end

    assign rd_data  = bank_q.rdata;
    assign rd_valid = bank_q.rvalid;
    assign active   = bank_q.active;
    assign commit   = bank_q.xfer;

    // R5
    r5_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_q.xfer && !(wr_en && wr_xfer && wr_data[0])) |=> !bank_q.xfer);

    // R9
    r9_rdvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    // R9
    r9_rdidle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    // R6
    r6_unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_hit && !rd_xfer) |=> (rd_data == 8'h00));

endmodule

// File: rtl/cfgbank_top.sv
module cfgbank_top
    import cfgbank_pkg::*;
#(
    parameter logic [7:0] FUNC_LO   = 8'h08,
    parameter logic [7:0] FUNC_HI   = 8'h2D,
    parameter logic [7:0] XFER_ADDR = 8'hFF,
    parameter logic [7:0] STAB_ADDR = 8'h09,
    parameter logic [7:0] STAB_DFLT = 8'h01
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       rd_en,
    input  logic [7:0] rd_addr,
    output logic [7:0] rd_data,
    output logic       rd_valid,
    output logic [(CHIP_SLOTS + int'(FUNC_HI) - int'(FUNC_LO) + 1)*8-1:0] active_cfg,
    output logic       stab_clk_en
);

    localparam int NSLOT     = CHIP_SLOTS + int'(FUNC_HI) - int'(FUNC_LO) + 1;
    localparam int SW        = $clog2(NSLOT);
    localparam int STAB_SLOT = CHIP_SLOTS + int'(STAB_ADDR) - int'(FUNC_LO);

    logic          w_hit, w_direct, w_xfer;
    logic [SW-1:0] w_slot;
    logic          r_hit, r_direct, r_xfer;
    logic [SW-1:0] r_slot;
    logic [NSLOT-1:0][7:0] act;
    logic          commit;

    cfgbank_decode #(.FUNC_LO(FUNC_LO), .FUNC_HI(FUNC_HI), .XFER_ADDR(XFER_ADDR), .SW(SW))
        u_wdec (.addr(wr_addr), .hit(w_hit), .direct(w_direct), .is_xfer(w_xfer), .slot(w_slot));

    cfgbank_decode #(.FUNC_LO(FUNC_LO), .FUNC_HI(FUNC_HI), .XFER_ADDR(XFER_ADDR), .SW(SW))
        u_rdec (.addr(rd_addr), .hit(r_hit), .direct(r_direct), .is_xfer(r_xfer), .slot(r_slot));

    cfgbank_store #(.NSLOT(NSLOT), .SW(SW), .FUNC_LO(FUNC_LO),
                    .STAB_ADDR(STAB_ADDR), .STAB_DFLT(STAB_DFLT))
        u_store (
            .clk(clk), .rst_n(rst_n),
            .wr_en(wr_en), .wr_hit(w_hit), .wr_direct(w_direct), .wr_xfer(w_xfer),
            .wr_slot(w_slot), .wr_data(wr_data),
            .rd_en(rd_en), .rd_hit(r_hit), .rd_xfer(r_xfer), .rd_slot(r_slot),
            .rd_data(rd_data), .rd_valid(rd_valid),
            .active(act), .commit(commit)
        );

    logic unused_rd_direct;
    assign unused_rd_direct = r_direct;

    for (genvar k = 0; k < NSLOT; k++) begin : g_flat
        assign active_cfg[k*8 +: 8] = act[k];
    end

    if (STAB_SLOT >= CHIP_SLOTS && STAB_SLOT < NSLOT) begin : g_stab
        assign stab_clk_en = act[STAB_SLOT][0];
    end else begin : g_nostab
        assign stab_clk_en = 1'b0;
    end

    // R2
    r2_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit && !(wr_en && w_hit && w_direct)) |=> $stable(active_cfg));

    // R8
    r8_stab_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(stab_clk_en));

endmodule

// File: tb/cfgbank_top_test.sv
module cfgbank_top_test;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NS = 43;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic rd_en = 1'b0;
    logic [7:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic rd_valid;
    logic [NS*8-1:0] active_cfg;
    logic stab_clk_en;

    always #2.5 clk = ~clk;

    cfgbank_top uut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_valid(rd_valid),
        .active_cfg(active_cfg), .stab_clk_en(stab_clk_en)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] exp;
        logic [7:0] addr;
        string      tag;
    } rd_item_t;
    rd_item_t sb[$];

    // reference model, built from the requirements
    logic [7:0] m_stage [256];
    logic [7:0] m_act   [256];
    logic       m_pend;

    function automatic bit m_impl(input logic [7:0] a);
        return (a <= 8'h02) || (a == 8'h04) || (a == 8'h05) || (a >= 8'h08 && a <= 8'h2D);
    endfunction

    function automatic bit m_direct(input logic [7:0] a);
        return (a == 8'h00) || (a == 8'h02) || (a == 8'h04) || (a == 8'h05);
    endfunction

    function automatic logic [7:0] m_read(input logic [7:0] a);
        if (a == 8'hFF) return {7'b0, m_pend};
        if (m_impl(a))  return m_act[a];
        return 8'h00;
    endfunction

    function automatic logic [NS*8-1:0] m_flat();
        logic [NS*8-1:0] v;
        logic [7:0] order [5];
        order = '{8'h00, 8'h01, 8'h02, 8'h04, 8'h05};
        for (int k = 0; k < 5; k++) v[k*8 +: 8] = m_act[order[k]];
        for (int k = 5; k < NS; k++) v[k*8 +: 8] = m_act[8'(k + 3)];
        return v;
    endfunction

    task automatic m_reset();
        for (int a = 0; a < 256; a++) begin
            m_stage[a] = 8'h00;
            m_act[a]   = 8'h00;
        end
        m_stage[8'h09] = 8'h01;
        m_act[8'h09]   = 8'h01;
        m_pend = 1'b0;
    endtask

    task automatic chk(input bit ok, input string req, input logic [NS*8-1:0] act_v,
                       input logic [NS*8-1:0] exp_v);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act_v, exp_v);
        end
    endtask

    // driver: one clock cycle per call
    task automatic step(input bit we, input logic [7:0] wa, input logic [7:0] wd,
                        input bit re, input logic [7:0] ra, input string tag);
        bit old_pend;
        rd_item_t it;
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd;
        rd_en = re; rd_addr = ra;
        if (re) begin
            it.exp = m_read(ra); it.addr = ra; it.tag = tag;
            sb.push_back(it);
        end
        @(posedge clk);
        #1;
        old_pend = m_pend;
        if (old_pend) begin
            for (int a = 0; a < 256; a++)
                if (m_impl(8'(a)) && !m_direct(8'(a))) m_act[a] = m_stage[a];
            m_pend = 1'b0;
        end
        if (we) begin
            if (wa == 8'hFF) m_pend = wd[0];
            else if (m_impl(wa)) begin
                m_stage[wa] = wd;
                if (m_direct(wa)) m_act[wa] = wd;
            end
        end
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        step(1'b1, a, d, 1'b0, 8'h00, "");
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        step(1'b0, 8'h00, 8'h00, 1'b1, a, tag);
    endtask

    task automatic idle();
        step(1'b0, 8'h00, 8'h00, 1'b0, 8'h00, "");
    endtask

    task automatic chk_ports(input string tag);
        chk(stab_clk_en == m_act[8'h09][0], {tag, " stab_clk_en"},
            {{(NS*8-1){1'b0}}, stab_clk_en}, {{(NS*8-1){1'b0}}, m_act[8'h09][0]});
        chk(active_cfg == m_flat(), {tag, " active_cfg"}, active_cfg, m_flat());
    endtask

    // monitor: pops expected reads as the design returns them
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R9 unexpected rd_valid", 1, 0);
            end else begin
                rd_item_t it;
                it = sb.pop_front();
                chk(rd_data == it.exp, $sformatf("%s addr=%02h", it.tag, it.addr),
                    {{(NS*8-8){1'b0}}, rd_data}, {{(NS*8-8){1'b0}}, it.exp});
            end
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            finish_run();
        end
    end

    initial begin
        m_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk_ports("R1");
        rd(8'h09, "R1 default 0x09");
        rd(8'h00, "R1 default 0x00");
        rd(8'h2D, "R1 default 0x2D");
        rd(8'hFF, "R1 commit bit idle");

        // R2 / R8 buffered write held back
        wr(8'h09, 8'h00);
        rd(8'h09, "R2 staged only");
        chk_ports("R8 before commit");

        // R3 / R5 commit and self-clear
        wr(8'hFF, 8'h01);
        rd(8'hFF, "R5 commit bit set");
        chk_ports("R3 during pending");
        rd(8'hFF, "R5 commit bit cleared");
        chk_ports("R8 after commit");
        rd(8'h09, "R3 committed 0x09");

        // R4 direct addresses
        wr(8'h02, 8'h5A);
        rd(8'h02, "R4 direct 0x02");
        wr(8'h05, 8'hC3);
        chk_ports("R4 direct active");
        wr(8'h01, 8'h33);
        rd(8'h01, "R2 buffered 0x01");

        // R6 unimplemented addresses
        wr(8'h03, 8'hFF);
        wr(8'h30, 8'h77);
        wr(8'h07, 8'h12);
        wr(8'hFE, 8'h01);
        rd(8'h03, "R6 read 0x03");
        rd(8'h30, "R6 read 0x30");
        rd(8'hFE, "R6 read 0xFE");
        chk_ports("R6 no effect");
        wr(8'hFF, 8'h01);
        idle();
        rd(8'h01, "R3 committed 0x01");
        chk_ports("R6 after commit");

        // R7 write in the pending-commit cycle
        wr(8'h10, 8'hAA);
        wr(8'hFF, 8'h01);
        wr(8'h10, 8'hBB);
        rd(8'h10, "R7 old staged value");
        wr(8'hFF, 8'h01);
        idle();
        rd(8'h10, "R7 new value after second commit");

        // R5 clear-bit write starts nothing
        wr(8'h20, 8'h11);
        wr(8'hFF, 8'h00);
        idle();
        rd(8'h20, "R5 no commit on bit0 clear");
        rd(8'hFF, "R5 still idle");

        // R9 read in the same cycle as a direct write
        step(1'b1, 8'h04, 8'h66, 1'b1, 8'h04, "R9 pre-write value");
        rd(8'h04, "R9 post-write value");

        // R10 bulk pattern across the function area
        for (int a = 8'h08; a <= 8'h2D; a++) wr(8'(a), 8'(a * 7 + 3));
        wr(8'hFF, 8'h01);
        idle();
        chk_ports("R10 layout");
        for (int a = 8'h08; a <= 8'h2D; a++) rd(8'(a), "R10 bulk readback");

        idle();
        idle();
        chk(sb.size() == 0, "R9 outstanding reads", sb.size(), 0);
        done = 1'b1;
        finish_run();
    end

endmodule